// File: doc/BRIEF.md
# Shadowed Lockable Nonvolatile Register File

This block is the byte-addressed register space behind a serial command engine. The engine hands over whole bytes: an opcode, then an address, then data. The space is 256 bytes wide but sparsely populated. It holds these locations:

- a protection flag/enable register;
- a read-only status byte;
- a nonvolatile-control register;
- a special feature register;
- two 4-byte nonvolatile blocks.

Each nonvolatile block is reached through a shadow RAM copy. Host writes land only in the shadow. A separate copy command commits a block to the nonvolatile store, and that commit takes a parameterised number of clock ticks. A recall command reloads the shadow from the store. A lock command makes a block permanently read-only.

The nonvolatile store is modelled as registers with a busy timer. While a copy runs, a busy flag is visible and writes to block addresses are refused. Two commands are guarded. A lock only fires when the command right before it was a write that set the arming bit. Copy and lock are both refused while the device is asleep. Recalling block 1 also refreshes the status byte, whose bit 4 selects the net-address read opcode used elsewhere.

Top module: `shadow_nv_regfile`

## Requirements
- R1: After reset, address 00h reads 53h (with both mirror inputs low), 01h reads 00h, 07h reads 00h, 08h reads 80h, every block byte reads 00h, and `rnaop` is 0.
- R2: Address 01h is read-only. Every address outside 00h, 01h, 07h, 08h, 20h–23h and 30h–33h reads 00h and ignores writes.
- R3: Opcodes 69h (read) and 6Ch (write) take a start address. The pointer steps by one after each byte and wraps from FFh to 00h. Read data is valid on `rd_data` as soon as the address byte (or the previous `rd_ack`) has been taken.
- R4: A pulse on `txn_start` ends any stream, so later bytes are not written. An opcode other than 69h, 6Ch, 48h, B8h or 6Ah causes the rest of the transaction to be ignored.
- R5: Writes to block bytes change only the shadow. Copy (48h, address) commits the 4-byte block containing the address. Recall (B8h, address) reloads that block's shadow from the store.
- R6: From the edge that takes a copy's address byte, bit 7 of 07h reads 1 for exactly COPY_TICKS cycles. During that time, writes to block addresses and further copy or recall commands are ignored, while other registers stay writable.
- R7: For a locked block, writes and copies are ignored, and recall still reloads the shadow.
- R8: Lock (6Ah, address) sets the block's lock flag (07h bit 0 for block 0, bit 1 for block 1) and clears the arming bit 07h bit 6. It does so only when 07h bit 6 is 1 and the command just before it wrote 07h with bit 6 set. Any other command in between disarms it. Lock flags never clear.
- R9: While `sleep` is 1, copy and lock commands are ignored.
- R10: Recall of block 1 loads the status byte at 01h from stored byte 31h, and `rnaop` equals status bit 4. A copy alone leaves the status byte unchanged.
- R11: In 00h, bits 7, 6, 4, 1 and 0 are writable. Bit 5 reads 0. Bit 3 mirrors `chg_mirror` and bit 2 mirrors `dis_mirror`. In 08h only bits 7 and 0 are writable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| txn_start | input | 1 | One-cycle pulse: a new transaction begins, next byte is an opcode |
| byte_valid | input | 1 | One-cycle strobe: `byte_in` holds a complete received byte |
| byte_in | input | 8 | Received byte (opcode, address or write data) |
| rd_ack | input | 1 | The engine has shifted out `rd_data`; advance the pointer |
| sleep | input | 1 | Device is in its low-power mode |
| chg_mirror | input | 1 | Current state of the charge switch drive |
| dis_mirror | input | 1 | Current state of the discharge switch drive |
| rd_data | output | 8 | Byte at the pointer during a read stream, otherwise 00h |
| prot_q | output | 8 | Stored protection flags and enables (writable bits only) |
| spf_q | output | 8 | Stored special feature bits |
| rnaop | output | 1 | Net-address read opcode select from status bit 4 |

## Verification
Each write takes effect at the clock edge that takes its data byte. Read data is valid right after the edge that takes the address byte or an `rd_ack`. The bench drives every input at a falling edge and samples at a later falling edge, so each result is read half a cycle after the edge that makes it. The busy window is checked cycle by cycle: a read of 07h is held on the pointer with no `rd_ack`, and bit 7 is compared at every falling edge against a count of rising edges since the copy's address byte was taken. Bytes written during that window, and the rejected copy, lock and recall cases, are checked afterwards by reading back the locations they could have changed.

// File: rtl/nvrf_pkg.sv
package nvrf_pkg;
  localparam int BYTE_W    = 8;
  localparam int NUM_BLK   = 2;
  localparam int BLK_BYTES = 4;
  localparam int BLK_W     = (NUM_BLK > 1) ? $clog2(NUM_BLK) : 1;
  localparam int OFS_W     = $clog2(BLK_BYTES);

  typedef logic [BYTE_W-1:0] byte_t;
  typedef logic [NUM_BLK-1:0][BLK_BYTES-1:0][BYTE_W-1:0] store_t;

  // command opcodes
  localparam byte_t OP_READ   = 8'h69;
  localparam byte_t OP_WRITE  = 8'h6C;
  localparam byte_t OP_COPY   = 8'h48;
  localparam byte_t OP_RECALL = 8'hB8;
  localparam byte_t OP_LOCK   = 8'h6A;

  // register addresses
  localparam byte_t A_PROT     = 8'h00;
  localparam byte_t A_STAT     = 8'h01;
  localparam byte_t A_NVCTL    = 8'h07;
  localparam byte_t A_SPF      = 8'h08;
  localparam byte_t A_BLK_BASE = 8'h20;   // blocks every 16 bytes from here

  localparam byte_t PROT_WMASK = 8'hD3;
  localparam byte_t SPF_WMASK  = 8'h81;
  localparam byte_t PROT_RST   = 8'h53;
  localparam byte_t SPF_RST    = 8'h80;
  localparam int    CHG_BIT    = 3;
  localparam int    DIS_BIT    = 2;
  localparam int    ARM_BIT    = 6;
  localparam int    BUSY_BIT   = 7;
  localparam int    RNAOP_BIT  = 4;
  localparam int    STAT_BLK   = 1;       // status image lives in block 1 ...
  localparam int    STAT_OFS   = 1;       // ... at byte offset 1

  typedef enum logic [2:0] {S_OP, S_ADDR, S_WR, S_RD, S_HALT} seq_state_e;

  function automatic logic blk_hit(input byte_t a);
    byte_t rel;
    rel = a - A_BLK_BASE;
    return (a >= A_BLK_BASE) && (rel[7:4] < 4'(NUM_BLK)) && (rel[3:0] < 4'(BLK_BYTES));
  endfunction

  function automatic logic [BLK_W-1:0] blk_idx(input byte_t a);
    byte_t rel;
    rel = a - A_BLK_BASE;
    return rel[4 +: BLK_W];
  endfunction

  function automatic logic [OFS_W-1:0] blk_ofs(input byte_t a);
    return a[OFS_W-1:0];
  endfunction
endpackage

// File: rtl/nvrf_cmd_seq.sv
module nvrf_cmd_seq
  import nvrf_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  txn_start,
  input  logic  byte_valid,
  input  byte_t byte_in,
  input  logic  rd_ack,
  output logic  op_start,
  output logic  exec,
  output byte_t exec_op,
  output logic  wr_en,
  output logic  rd_active,
  output byte_t ptr
);
  seq_state_e state_q, state_d;
  byte_t      op_q, op_d, ptr_q, ptr_d;

  function automatic logic known_op(input byte_t o);
    return (o == OP_READ) || (o == OP_WRITE) || (o == OP_COPY) ||
           (o == OP_RECALL) || (o == OP_LOCK);
  endfunction

  always_comb begin
    state_d  = state_q;
    op_d     = op_q;
    ptr_d    = ptr_q;
    op_start = 1'b0;
    exec     = 1'b0;
    wr_en    = 1'b0;
    if (txn_start) begin
      state_d = S_OP;
    end else begin
      unique case (state_q)
        S_OP: if (byte_valid) begin
          op_start = 1'b1;
          op_d     = byte_in;
          state_d  = known_op(byte_in) ? S_ADDR : S_HALT;
        end
        S_ADDR: if (byte_valid) begin
          exec    = 1'b1;
          ptr_d   = byte_in;
          state_d = (op_q == OP_READ)  ? S_RD :
                    (op_q == OP_WRITE) ? S_WR : S_HALT;
        end
        S_WR: if (byte_valid) begin
          wr_en = 1'b1;
          ptr_d = ptr_q + 8'd1;
        end
        S_RD: if (rd_ack) ptr_d = ptr_q + 8'd1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_HALT;
      op_q    <= '0;
      ptr_q   <= '0;
    end else begin
      state_q <= state_d;
      if (op_start) op_q <= op_d;
      if (exec || wr_en || (state_q == S_RD && rd_ack && !txn_start)) ptr_q <= ptr_d;
    end
  end

  assign exec_op   = op_q;
  assign rd_active = (state_q == S_RD);
  assign ptr       = ptr_q;

  // R3: a write stream at FFh continues at 00h
  p_wrap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WR && byte_valid && !txn_start && ptr_q == 8'hFF) |=> (ptr_q == 8'h00));
endmodule

// File: rtl/nvrf_nv_store.sv
module nvrf_nv_store
  import nvrf_pkg::*;
#(
  parameter int COPY_TICKS = 32
)(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               copy_go,
  input  logic               lock_go,
  input  logic [BLK_W-1:0]   cmd_blk,
  input  store_t             shadow_q,
  output store_t             nv_q,
  output logic               busy,
  output logic [NUM_BLK-1:0] locked
);
  localparam int CNT_W = $clog2(COPY_TICKS + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [BLK_W-1:0] cblk_q;
  logic             cnt_en, commit;

  always_comb begin
    busy   = (cnt_q != '0);
    commit = (cnt_q == CNT_W'(1));
    cnt_en = copy_go || busy;
    cnt_d  = copy_go ? CNT_W'(COPY_TICKS) : cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      cblk_q <= '0;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (copy_go) cblk_q <= cmd_blk;
    end
  end

  for (genvar g = 0; g < NUM_BLK; g++) begin : g_blk
    logic [BLK_BYTES-1:0][BYTE_W-1:0] cell_q;
    logic lk_q, commit_g, lock_g;
    assign commit_g = commit && (cblk_q == BLK_W'(g));
    assign lock_g   = lock_go && (cmd_blk == BLK_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        cell_q <= '0;
        lk_q   <= 1'b0;
      end else begin
        if (commit_g) cell_q <= shadow_q[g];
        if (lock_g)   lk_q   <= 1'b1;
      end
    end
    assign nv_q[g]   = cell_q;
    assign locked[g] = lk_q;
  end

  // R6: an accepted copy raises the busy flag on the next cycle
  p_busy_after_copy_r6: assert property (@(posedge clk) disable iff (!rst_n)
    copy_go |=> busy);
  // R6: the command decode never starts a copy on top of a running one
  p_copy_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    copy_go |-> !busy);
  // R8: lock flags only ever rise, and only through a lock command
  p_lock_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (locked != $past(locked)) |-> ($past(lock_go) && ((locked & $past(locked)) == $past(locked))));
endmodule

// File: rtl/nvrf_reg_bank.sv
module nvrf_reg_bank
  import nvrf_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  byte_t              addr,
  input  byte_t              wr_data,
  input  logic               op_start,
  input  byte_t              op_code,
  input  logic               exec,
  input  logic               busy,
  input  logic [NUM_BLK-1:0] locked,
  input  logic               recall_go,
  input  logic               lock_go,
  input  logic [BLK_W-1:0]   cmd_blk,
  input  store_t             nv_q,
  input  logic               chg_mirror,
  input  logic               dis_mirror,
  output byte_t              rd_byte,
  output byte_t              prot_q,
  output byte_t              spf_q,
  output logic               rnaop,
  output logic               lock_ready,
  output store_t             shadow_q
);
  byte_t  stat_q, stat_d, prot_d, spf_d, ctl_img;
  logic   arm_bit_q, arm_bit_d, armed_q, armed_d;
  logic   wr_prot, wr_spf, wr_ctl, wr_nv, stat_en, arm_en, armed_en, shadow_en;
  store_t shadow_d;

  always_comb begin
    wr_prot   = wr_en && (addr == A_PROT);
    wr_spf    = wr_en && (addr == A_SPF);
    wr_ctl    = wr_en && (addr == A_NVCTL);
    wr_nv     = wr_en && blk_hit(addr) && !busy && !locked[blk_idx(addr)];
    prot_d    = wr_data & PROT_WMASK;
    spf_d     = wr_data & SPF_WMASK;
    arm_en    = lock_go || wr_ctl;
    arm_bit_d = lock_go ? 1'b0 : wr_data[ARM_BIT];
    armed_en  = wr_ctl || exec || (op_start && op_code != OP_LOCK);
    armed_d   = wr_ctl ? wr_data[ARM_BIT] : 1'b0;
    stat_en   = recall_go && (cmd_blk == BLK_W'(STAT_BLK));
    stat_d    = nv_q[STAT_BLK][STAT_OFS];
    shadow_en = recall_go || wr_nv;
    shadow_d  = shadow_q;
    if (recall_go)  shadow_d[cmd_blk] = nv_q[cmd_blk];
    else if (wr_nv) shadow_d[blk_idx(addr)][blk_ofs(addr)] = wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prot_q    <= PROT_RST;
      spf_q     <= SPF_RST;
      stat_q    <= '0;
      arm_bit_q <= 1'b0;
      armed_q   <= 1'b0;
      shadow_q  <= '0;
    end else begin
      if (wr_prot)   prot_q    <= prot_d;
      if (wr_spf)    spf_q     <= spf_d;
      if (stat_en)   stat_q    <= stat_d;
      if (arm_en)    arm_bit_q <= arm_bit_d;
      if (armed_en)  armed_q   <= armed_d;
      if (shadow_en) shadow_q  <= shadow_d;
    end
  end

  always_comb begin
    ctl_img                 = '0;
    ctl_img[BUSY_BIT]       = busy;
    ctl_img[ARM_BIT]        = arm_bit_q;
    ctl_img[NUM_BLK-1:0]    = locked;
    rd_byte = '0;
    unique case (addr)
      A_PROT:  begin
        rd_byte          = prot_q;
        rd_byte[CHG_BIT] = chg_mirror;
        rd_byte[DIS_BIT] = dis_mirror;
      end
      A_STAT:  rd_byte = stat_q;
      A_NVCTL: rd_byte = ctl_img;
      A_SPF:   rd_byte = spf_q;
      default: if (blk_hit(addr)) rd_byte = shadow_q[blk_idx(addr)][blk_ofs(addr)];
    endcase
  end

  assign rnaop      = stat_q[RNAOP_BIT];
  assign lock_ready = arm_bit_q && armed_q;

  // R6: shadow RAM is frozen while a copy is in progress
  p_shadow_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(shadow_q));
  // R8: an executed lock always leaves the arming bit cleared
  p_arm_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_go |=> !arm_bit_q);
  // R8: decode only fires a lock when the arming write came just before
  p_lock_armed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    lock_go |-> (arm_bit_q && armed_q));
endmodule

// File: rtl/shadow_nv_regfile.sv
module shadow_nv_regfile
  import nvrf_pkg::*;
#(
  parameter int COPY_TICKS = 32
)(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       txn_start,
  input  logic       byte_valid,
  input  logic [7:0] byte_in,
  input  logic       rd_ack,
  input  logic       sleep,
  input  logic       chg_mirror,
  input  logic       dis_mirror,
  output logic [7:0] rd_data,
  output logic [7:0] prot_q,
  output logic [7:0] spf_q,
  output logic       rnaop
);
  logic               op_start, exec, wr_en, rd_active, busy, lock_ready;
  logic               cmd_hit, copy_go, recall_go, lock_go;
  logic [BLK_W-1:0]   cmd_blk;
  logic [NUM_BLK-1:0] locked;
  byte_t              exec_op, ptr, rd_byte;
  store_t             shadow_q, nv_q;

  nvrf_cmd_seq u_seq (
    .clk, .rst_n, .txn_start, .byte_valid, .byte_in, .rd_ack,
    .op_start, .exec, .exec_op, .wr_en, .rd_active, .ptr
  );

  // command decode at the address byte
  always_comb begin
    cmd_hit   = blk_hit(byte_in);
    cmd_blk   = blk_idx(byte_in);
    copy_go   = exec && (exec_op == OP_COPY) && cmd_hit && !locked[cmd_blk] && !sleep && !busy;
    recall_go = exec && (exec_op == OP_RECALL) && cmd_hit && !busy;
    lock_go   = exec && (exec_op == OP_LOCK) && cmd_hit && !sleep && lock_ready;
  end

  nvrf_nv_store #(.COPY_TICKS(COPY_TICKS)) u_nv (
    .clk, .rst_n, .copy_go, .lock_go, .cmd_blk, .shadow_q, .nv_q, .busy, .locked
  );

  nvrf_reg_bank u_regs (
    .clk, .rst_n, .wr_en, .addr(ptr), .wr_data(byte_in), .op_start, .op_code(byte_in),
    .exec, .busy, .locked, .recall_go, .lock_go, .cmd_blk, .nv_q, .chg_mirror,
    .dis_mirror, .rd_byte, .prot_q, .spf_q, .rnaop, .lock_ready, .shadow_q
  );

  assign rd_data = rd_active ? rd_byte : 8'h00;
endmodule

// File: tb/tb_shadow_nv_regfile.sv
`timescale 1ns/100ps
module tb_shadow_nv_regfile;
  localparam int N = 32;
  localparam logic [7:0] RD = 8'h69, WR = 8'h6C, CP = 8'h48, RC = 8'hB8, LK = 8'h6A;

  logic clk = 1'b0, rst_n = 1'b0;
  logic txn_start = 0, byte_valid = 0, rd_ack = 0, sleep = 0, chg_mirror = 0, dis_mirror = 0;
  logic [7:0] byte_in = 0, rd_data, prot_q, spf_q;
  logic rnaop;
  int nchk = 0, nfail = 0, cyc = 0;
  bit done = 0;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc++;

  shadow_nv_regfile #(.COPY_TICKS(N)) dut (.*);

  // {req, addr, write data, expected readback}
  localparam logic [31:0] VEC [15] = '{
    32'h0B00FFD3, 32'h0B000000,   // R11 protection byte masks
    32'h02015A00, 32'h02057700,   // R2 read-only / reserved
    32'h0B08FF81, 32'h0B080000,   // R11 special feature masks
    32'h05203C3C, 32'h0523C3C3,   // R5 shadow block 0
    32'h05301111, 32'h0533EEEE,   // R5 shadow block 1
    32'h02249900, 32'h02401200, 32'h02FFAB00, // R2 reserved
    32'h08074040, 32'h08070000    // R8 arming bit
  };

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    nchk++;
    if (got !== exp) begin
      nfail++;
      $display("FAIL %s got %02h expected %02h", tag, got, exp);
    end
  endtask
  task automatic txn();
    @(negedge clk) txn_start = 1; @(negedge clk) txn_start = 0;
  endtask
  task automatic send(input logic [7:0] b);
    @(negedge clk) begin byte_valid = 1; byte_in = b; end
    @(negedge clk) byte_valid = 0;
  endtask
  task automatic cmd(input logic [7:0] op, input logic [7:0] a);
    txn(); send(op); send(a);
  endtask
  task automatic wr1(input logic [7:0] a, input logic [7:0] d);
    cmd(WR, a); send(d);
  endtask
  task automatic rd1(input logic [7:0] a, output logic [7:0] v);
    cmd(RD, a); v = rd_data;
  endtask
  task automatic ack();
    rd_ack = 1; @(negedge clk); rd_ack = 0;
  endtask
  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      nfail++; nchk++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int c0;
    idle(4); rst_n = 1; idle(2);

    // R1 reset state
    rd1(8'h00, v); chk("R1 00h", v, 8'h53);
    rd1(8'h01, v); chk("R1 01h", v, 8'h00);
    rd1(8'h07, v); chk("R1 07h", v, 8'h00);
    rd1(8'h08, v); chk("R1 08h", v, 8'h80);
    rd1(8'h21, v); chk("R1 21h", v, 8'h00);
    chk("R1 rnaop", {7'd0, rnaop}, 8'h00);

    for (int i = 0; i < 15; i++) begin
      wr1(VEC[i][23:16], VEC[i][15:8]);
      rd1(VEC[i][23:16], v);
      chk($sformatf("R%0d table addr %02h", VEC[i][31:24], VEC[i][23:16]), v, VEC[i][7:0]);
    end

    // R3 write stream wrapping FFh -> 00h, then read stream
    cmd(WR, 8'hFE); send(8'h11); send(8'h22); send(8'hA5); send(8'h5A);
    cmd(RD, 8'hFF);
    chk("R3 rd FFh", rd_data, 8'h00); ack();
    chk("R3 rd 00h after wrap", rd_data, 8'h81); ack();
    chk("R3 rd 01h", rd_data, 8'h00);
    chk("R3 prot_q port", prot_q, 8'h81);
    cmd(WR, 8'h20); send(8'h01); send(8'h02); send(8'h03); send(8'h04);
    cmd(RD, 8'h20);
    for (int i = 0; i < 4; i++) begin
      chk("R3 block stream", rd_data, 8'(i + 1)); ack();
    end

    // R4 restart ends the stream; unknown opcode ignores the rest
    cmd(WR, 8'h30); send(8'h55);
    txn(); send(8'h66); send(8'h77); send(8'h31);
    rd1(8'h30, v); chk("R4 byte before restart", v, 8'h55);
    rd1(8'h31, v); chk("R4 nothing after restart", v, 8'h00);

    // R5 recall restores store contents; copy commits
    cmd(RC, 8'h20);
    rd1(8'h20, v); chk("R5 recall blank store", v, 8'h00);
    cmd(WR, 8'h20); send(8'h10); send(8'h20); send(8'h30); send(8'h40);
    cmd(CP, 8'h22);
    c0 = cyc;
    cmd(RD, 8'h07);
    // R6 busy window, counted in rising edges since the copy address byte
    while (cyc - c0 <= N + 2) begin
      chk($sformatf("R6 busy at +%0d", cyc - c0), {7'd0, rd_data[7]}, {7'd0, (cyc - c0) < N});
      @(negedge clk);
    end
    wr1(8'h20, 8'h99);
    cmd(RC, 8'h21);
    rd1(8'h20, v); chk("R5 recall after copy", v, 8'h10);
    rd1(8'h23, v); chk("R5 recall last byte", v, 8'h40);

    // R6 block writes refused during copy, other registers still written
    cmd(CP, 8'h20);
    wr1(8'h21, 8'h77); wr1(8'h08, 8'h81);
    idle(N + 4);
    rd1(8'h21, v); chk("R6 shadow write refused", v, 8'h20);
    rd1(8'h08, v); chk("R6 other write taken", v, 8'h81);
    chk("R6 spf_q port", spf_q, 8'h81);

    // R10 status reload only on recall of block 1
    wr1(8'h31, 8'h10); cmd(CP, 8'h30); idle(N + 4);
    chk("R10 rnaop after copy", {7'd0, rnaop}, 8'h00);
    rd1(8'h01, v); chk("R10 status after copy", v, 8'h00);
    wr1(8'h31, 8'h00); cmd(RC, 8'h30);
    rd1(8'h31, v); chk("R10 shadow 31h recalled", v, 8'h10);
    rd1(8'h01, v); chk("R10 status reloaded", v, 8'h10);
    chk("R10 rnaop set", {7'd0, rnaop}, 8'h01);

    // R8 armed lock of block 0; R7 locked behaviour
    wr1(8'h20, 8'hAB); wr1(8'h07, 8'h40); cmd(LK, 8'h20);
    rd1(8'h07, v); chk("R8 lock block0", v, 8'h01);
    wr1(8'h20, 8'h55);
    rd1(8'h20, v); chk("R7 write to locked", v, 8'hAB);
    cmd(CP, 8'h20);
    rd1(8'h07, v); chk("R7 copy of locked not busy", v, 8'h01);
    cmd(RC, 8'h20);
    rd1(8'h20, v); chk("R7 recall of locked", v, 8'h10);

    // R8 disarmed by intervening command
    wr1(8'h07, 8'h40); rd1(8'h00, v); cmd(LK, 8'h30);
    rd1(8'h07, v); chk("R8 unarmed lock", v, 8'h41);

    // R9 copy and lock refused in sleep
    wr1(8'h32, 8'h5C); wr1(8'h07, 8'h40);
    sleep = 1;
    cmd(LK, 8'h30); cmd(CP, 8'h30);
    rd1(8'h07, v); chk("R9 sleep lock and copy", v, 8'h41);
    sleep = 0;
    cmd(RC, 8'h30);
    rd1(8'h32, v); chk("R9 sleep copy not stored", v, 8'h00);

    // R8 armed lock of block 1, R7 write refused
    wr1(8'h07, 8'h40); cmd(LK, 8'h33);
    rd1(8'h07, v); chk("R8 lock block1", v, 8'h03);
    wr1(8'h30, 8'hFF);
    rd1(8'h30, v); chk("R7 block1 locked write", v, 8'h55);

    // R11 mirror bits
    chg_mirror = 1; dis_mirror = 1;
    rd1(8'h00, v); chk("R11 mirrors", v, 8'h8D);
    chg_mirror = 0;
    rd1(8'h00, v); chk("R11 mirror charge low", v, 8'h85);

    done = 1;
    $display("%0d/%0d checks passed", nchk - nfail, nchk);
    $finish;
  end
endmodule